// File: doc/BRIEF.md
# Quad Color Packer with Masked Merge

This block takes the four fragment colors of a 2x2 pixel quad and turns each into a packed 32-bit word. Every color has four channels, and each channel is a 16-bit unsigned fixed-point value in which 0x8000 stands for 1.0. A format select decides which byte of the word each channel lands in. The block then merges the packed words with the words already held in the framebuffer, using the quad's per-pixel alive mask. The result is the four words a tile store writes back. If a pixel is dead, its old framebuffer word passes through unchanged.

The path has one register stage. A valid strobe on the input side yields a store strobe and four result words on the next cycle. An unknown format code does not corrupt the tile: it behaves as if every pixel were dead.

Top module: `quad_pack_merge`

## Requirements
- R1: After reset, `store_o` is 0 and all four `word_o` lanes are 0.
- R2: `store_o` is 1 in the cycle after `valid_i` was 1, and 0 in the cycle after `valid_i` was 0.
- R3: Each channel is converted to 8 bits as follows. A value of 0x8000 or above becomes 0xFF. A value below 0x8000 becomes bits [14:7], so 0x4000 becomes 0x80 and 0x00FF becomes 0x01.
- R4: With format code 0 (ARGB), the packed word holds blue in [7:0], green in [15:8], red in [23:16] and alpha in [31:24]. For example, R=0x11, G=0x44, B=0x77, A=0xAA packs to 0xAA114477.
- R5: With format code 1 (BGRA), the packed word holds alpha in [7:0], red in [15:8], green in [23:16] and blue in [31:24].
- R6: When mask bit i is 1, lane i of `word_o` carries the packed new color.
- R7: When mask bit i is 0, lane i of `word_o` equals lane i of `fb_i` exactly.
- R8: With format code 2 or 3, every lane of `word_o` equals the matching `fb_i` lane, whatever the mask.
- R9: While `valid_i` is 0, `word_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | The quad inputs are valid in this cycle |
| fmt_i | input | 2 | Surface format: 0 = ARGB, 1 = BGRA, 2 and 3 = unsupported |
| mask_i | input | 4 | Per-pixel alive mask; bit i belongs to pixel i |
| red_i | input | 64 | Red channel of each pixel; pixel i uses bits [16i+15:16i] |
| green_i | input | 64 | Green channel of each pixel, same lane layout |
| blue_i | input | 64 | Blue channel of each pixel, same lane layout |
| alpha_i | input | 64 | Alpha channel of each pixel, same lane layout |
| fb_i | input | 128 | Existing framebuffer words; pixel i uses bits [32i+31:32i] |
| store_o | output | 1 | The result words are ready to store |
| word_o | output | 128 | Merged result words, same lane layout as `fb_i` |

## Verification
Each result is due exactly one clock edge after its stimulus, since the path has a single register stage. The bench drives the inputs on the falling edge and queues the expected words and strobe in a behavioural model. It compares them on the next falling edge, so each sample lands half a period after the rising edge that updates the outputs. Idle cycles are checked against the held value, and the reset value is checked before any stimulus.

// File: rtl/qpm_pkg.sv
package qpm_pkg;
    localparam int CH_W    = 16;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 32;
    localparam int NPIX    = 4;
    localparam int FMT_W   = 2;
    localparam logic [CH_W-1:0] ONE_VAL = 16'h8000;

    typedef enum logic [FMT_W-1:0] {
        FMT_ARGB = 2'd0,
        FMT_BGRA = 2'd1,
        FMT_RSV2 = 2'd2,
        FMT_RSV3 = 2'd3
    } surf_fmt_e;

    typedef struct packed {
        logic [BYTE_W-1:0] r;
        logic [BYTE_W-1:0] g;
        logic [BYTE_W-1:0] b;
        logic [BYTE_W-1:0] a;
    } px8_t;

    function automatic logic [BYTE_W-1:0] unorm_to_byte(input logic [CH_W-1:0] v);
        if (v >= ONE_VAL) return {BYTE_W{1'b1}};
        return v[CH_W-2 -: BYTE_W];
    endfunction

    function automatic logic fmt_known(input surf_fmt_e f);
        return (f == FMT_ARGB) || (f == FMT_BGRA);
    endfunction
endpackage

// File: rtl/qpm_chan_conv.sv
module qpm_chan_conv
    import qpm_pkg::*;
(
    input  logic [CH_W-1:0]   r_i,
    input  logic [CH_W-1:0]   g_i,
    input  logic [CH_W-1:0]   b_i,
    input  logic [CH_W-1:0]   a_i,
    output px8_t              px_o
);
    always_comb begin
        px_o.r = unorm_to_byte(r_i);
        px_o.g = unorm_to_byte(g_i);
        px_o.b = unorm_to_byte(b_i);
        px_o.a = unorm_to_byte(a_i);
    end

    // R3: saturation never yields a byte smaller than an in-range conversion
    always_comb begin
        a_r3_saturate: assert (r_i < ONE_VAL || px_o.r == 8'hFF);
    end
endmodule

// File: rtl/qpm_packer.sv
module qpm_packer
    import qpm_pkg::*;
(
    input  px8_t              px_i,
    input  surf_fmt_e         fmt_i,
    output logic [WORD_W-1:0] word_o
);
    logic [WORD_W-1:0] r_sh, g_sh, b_sh, a_sh;

    always_comb begin
        r_sh = '0; g_sh = '0; b_sh = '0; a_sh = '0;
        unique case (fmt_i)
            FMT_ARGB: begin
                b_sh = WORD_W'(px_i.b);
                g_sh = WORD_W'(px_i.g) << 8;
                r_sh = WORD_W'(px_i.r) << 16;
                a_sh = WORD_W'(px_i.a) << 24;
            end
            FMT_BGRA: begin
                a_sh = WORD_W'(px_i.a);
                r_sh = WORD_W'(px_i.r) << 8;
                g_sh = WORD_W'(px_i.g) << 16;
                b_sh = WORD_W'(px_i.b) << 24;
            end
            default: ;
        endcase
        word_o = r_sh | g_sh | b_sh | a_sh;
    end
endmodule

// File: rtl/quad_pack_merge.sv
module quad_pack_merge
    import qpm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     valid_i,
    input  logic [FMT_W-1:0]         fmt_i,
    input  logic [NPIX-1:0]          mask_i,
    input  logic [NPIX*CH_W-1:0]     red_i,
    input  logic [NPIX*CH_W-1:0]     green_i,
    input  logic [NPIX*CH_W-1:0]     blue_i,
    input  logic [NPIX*CH_W-1:0]     alpha_i,
    input  logic [NPIX*WORD_W-1:0]   fb_i,
    output logic                     store_o,
    output logic [NPIX*WORD_W-1:0]   word_o
);
    surf_fmt_e              fmt;
    logic                   known;
    logic [NPIX*WORD_W-1:0] merged;

    assign fmt   = surf_fmt_e'(fmt_i);
    assign known = fmt_known(fmt);

    for (genvar p = 0; p < NPIX; p++) begin : g_pix
        px8_t              px;
        logic [WORD_W-1:0] packed_w;
        qpm_chan_conv u_conv (
            .r_i (red_i  [p*CH_W +: CH_W]),
            .g_i (green_i[p*CH_W +: CH_W]),
            .b_i (blue_i [p*CH_W +: CH_W]),
            .a_i (alpha_i[p*CH_W +: CH_W]),
            .px_o(px)
        );
        qpm_packer u_pack (
            .px_i  (px),
            .fmt_i (fmt),
            .word_o(packed_w)
        );
        assign merged[p*WORD_W +: WORD_W] =
            (mask_i[p] && known) ? packed_w : fb_i[p*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_o <= 1'b0;
            word_o  <= '0;
        end else begin
            store_o <= valid_i;
            if (valid_i) word_o <= merged;
        end
    end

    a_r2_store_follows_valid: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> store_o);
    a_r2_no_spurious_store: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !store_o);
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(word_o));
    a_r8_unknown_passthrough: assert property (@(posedge clk) disable iff (rst)
        (valid_i && fmt_i[1]) |=> (word_o == $past(fb_i)));
    a_r7_dead_keeps_fb: assert property (@(posedge clk) disable iff (rst)
        (valid_i && mask_i == '0) |=> (word_o == $past(fb_i)));
endmodule

// File: tb/quad_pack_merge_test.sv
module quad_pack_merge_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_i = 1'b0;
    logic [1:0]   fmt_i = '0;
    logic [3:0]   mask_i = '0;
    logic [63:0]  red_i = '0, green_i = '0, blue_i = '0, alpha_i = '0;
    logic [127:0] fb_i = '0;
    logic         store_o;
    logic [127:0] word_o;

    int checks = 0;
    int fails  = 0;
    logic [127:0] exp_word = '0;
    logic         exp_store = 1'b0;

    always #2 clk = ~clk;

    quad_pack_merge uut (.*);

    function automatic int to8(input int v);
        if (v >= 32768) return 255;
        return v / 128;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stage one quad; model computes expected result due after next rising edge
    task automatic drive(input bit v, input int fmt, input logic [3:0] m,
                         input logic [15:0] r, input logic [15:0] g,
                         input logic [15:0] b, input logic [15:0] a, input logic [127:0] fb);
        @(negedge clk);
        valid_i = v; fmt_i = 2'(fmt); mask_i = m;
        red_i = {4{r}}; green_i = {4{g}}; blue_i = {4{b}}; alpha_i = {4{a}};
        fb_i = fb;
        // vary channel per lane so lanes differ
        red_i[31:16] = r ^ 16'h0100;
        for (int p = 0; v && p < 4; p++) begin
            int rr, gg, bb, aa;
            logic [31:0] w;
            rr = to8(int'(red_i[p*16 +: 16]));
            gg = to8(int'(g)); bb = to8(int'(b)); aa = to8(int'(a));
            if (fmt == 0) w = {aa[7:0], rr[7:0], gg[7:0], bb[7:0]};
            else          w = {bb[7:0], gg[7:0], rr[7:0], aa[7:0]};
            exp_word[p*32 +: 32] = (m[p] && fmt < 2) ? w : fb[p*32 +: 32];
        end
        exp_store = v;
        @(negedge clk);
        check("R2 store", {127'd0, store_o}, {127'd0, exp_store});
        check("R4/R5/R6/R7/R8/R9 words", word_o, exp_word);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset store", {127'd0, store_o}, 128'd0);
        check("R1 reset words", word_o, 128'd0);
        rst = 1'b0;
        // R4 worked example, lane0 exact
        drive(1, 0, 4'hF, 16'h0880, 16'h2200, 16'h3B80, 16'h5500, {4{32'hDEADBEEF}});
        check("R4 example lane0", {96'd0, word_o[31:0]}, {96'd0, 32'hAA114477});
        // R5 BGRA
        drive(1, 1, 4'hF, 16'h0880, 16'h2200, 16'h3B80, 16'h5500, {4{32'h01020304}});
        check("R5 bgra lane0", {96'd0, word_o[31:0]}, {96'd0, 32'h7744_11AA});
        // R3 saturation and scale
        drive(1, 0, 4'hF, 16'h8000, 16'hFFFF, 16'h4000, 16'h00FF, '0);
        check("R3 lane0", {96'd0, word_o[31:0]}, {96'd0, 32'h01FF_FF80});
        // R6/R7 partial masks
        drive(1, 0, 4'b0101, 16'h1234, 16'h7FFF, 16'h0000, 16'h9000, {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111});
        check("R7 dead lane1", {96'd0, word_o[63:32]}, {96'd0, 32'h22222222});
        drive(1, 1, 4'b1010, 16'h0ABC, 16'h3000, 16'h6000, 16'h7000, {4{32'hCAFEF00D}});
        drive(1, 0, 4'b0000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, {4{32'h55AA55AA}});
        // R8 unknown formats
        drive(1, 2, 4'hF, 16'h8000, 16'h1000, 16'h2000, 16'h3000, {4{32'h0BADF00D}});
        drive(1, 3, 4'hF, 16'h8000, 16'h1000, 16'h2000, 16'h3000, {4{32'h12345678}});
        // R9 idle holds
        drive(0, 0, 4'hF, 16'h7777, 16'h7777, 16'h7777, 16'h7777, '1);
        drive(0, 1, 4'h0, 16'h0, 16'h0, 16'h0, 16'h0, '0);
        for (int k = 0; k < 20; k++)
            drive(1, k % 2, 4'(k * 7), 16'(k * 3001), 16'(k * 1777), 16'(k * 4093), 16'(k * 2221),
                  {4{32'(k * 32'h01010101)}});
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule